// File: doc/BRIEF.md
# TDC Reference-Time Subtractor

A multi-hit TDC reports hit times against a readout trigger whose phase wanders. The trigger logic runs on a 250 MHz clock, so it can sit up to 4 ns away from the pretrigger. The TDC's common trigger is resynchronised to a 40 MHz clock, which adds up to 25 ns more. To cancel this wander, a copy of the pretrigger is wired into one ordinary high-resolution channel. This block uses that channel's hit as the time zero of each event and subtracts it from every hit time in the same event.

Words arrive as a stream of channel number, 21-bit unsigned time and an end-of-event flag. The reference hit can arrive at any place in an event, so the block stores each event whole. Once the final word is in, it plays the event back with 22-bit two's-complement corrected times. The reference channel's own words are corrected too. The earliest of them therefore comes out as zero, which gives the expected self-timing spike in a histogram. Two storage banks let the next event be written while the previous one is played back.

Top module: `refsub_top`

## Requirements
- R1: After reset, out_valid is low and stays low until a complete event has been accepted.
- R2: Every accepted word is output exactly once, in arrival order, with out_chan equal to the input channel. out_last is high on the final word of each event and on no other word. Events of one word up to DEPTH words are handled.
- R3: When the event contains a reference hit, out_time equals the hit time minus the reference time, as a TIME_W+1 bit two's-complement value. A hit earlier than the reference gives a negative result.
- R4: The reference hit may be any word of the event, including the final word, and still applies to all words of the event, including words that came before it.
- R5: If the reference channel has several hits in an event, the hit with the smallest time is the reference. Each reference-channel word is output as its offset from that hit, so the earliest comes out as 0.
- R6: If an event has no word on channel REF_CHAN, every output word of that event has out_noref = 1 and out_time equal to the raw time, zero-extended. When a reference exists, out_noref = 0 on every word of the event.
- R7: Reference state does not carry from one event to the next: an event without a reference hit is flagged even when the previous event had one.
- R8: A new event may begin on the cycle after the previous event's final word, while that event is still being output. Both events are output correctly and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_chan | input | CH_W | Channel number of the hit |
| in_time | input | TIME_W | Unsigned hit time |
| in_last | input | 1 | Final word of the event |
| out_valid | output | 1 | Output word present this cycle |
| out_chan | output | CH_W | Channel number of the hit |
| out_time | output | TIME_W+1 | Corrected two's-complement time, or raw time when out_noref is set |
| out_last | output | 1 | Final word of the event |
| out_noref | output | 1 | Event had no reference hit |

## Verification
Two things can happen in the same cycle: one bank is written with a new event while the other bank is played back. The final word of the new event can also land while the reader is releasing the other bank. The bench provokes this by sending two events with no idle cycle between them, so that the second event is written during the first event's playback. It judges the result by comparing both output streams word by word against corrections the bench computes from the requirements. This shows that neither the reference values nor the event lengths of the two banks leak into each other.

// File: rtl/refsub_pkg.sv
package refsub_pkg;
  typedef enum logic {RD_IDLE = 1'b0, RD_RUN = 1'b1} rd_state_t;
endpackage

// File: rtl/refsub_ram.sv
module refsub_ram #(
  parameter int AW = 6,
  parameter int DW = 29
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NWORDS = 2 ** AW;
  logic [DW-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/refsub_ref_track.sv
module refsub_ref_track #(
  parameter int CH_W     = 7,
  parameter int TIME_W   = 21,
  parameter int REF_CHAN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [TIME_W-1:0] in_time,
  input  logic              in_last,
  output logic [TIME_W-1:0] evt_ref,
  output logic              evt_found
);
  localparam logic [CH_W-1:0] REF_ID = CH_W'(REF_CHAN);

  logic              found_q;
  logic [TIME_W-1:0] min_q;
  logic              is_ref;
  logic              take;

  always_comb begin
    is_ref    = in_valid && (in_chan == REF_ID);
    take      = is_ref && (!found_q || (in_time < min_q));
    evt_ref   = take ? in_time : min_q;
    evt_found = found_q || is_ref;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      found_q <= 1'b0;
      min_q   <= '0;
    end else if (in_valid) begin
      if (in_last) begin
        found_q <= 1'b0;
      end else begin
        found_q <= evt_found;
        min_q   <= evt_ref;
      end
    end
  end

  // R5: a later reference hit never raises the running minimum
  assert_min_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (is_ref && found_q && !in_last) |=> (min_q <= $past(min_q)));
endmodule

// File: rtl/refsub_reader.sv
module refsub_reader
  import refsub_pkg::*;
#(
  parameter int CH_W     = 7,
  parameter int TIME_W   = 21,
  parameter int AW       = 5,
  parameter int LW       = 6,
  parameter int REF_CHAN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_ready,
  input  logic [LW-1:0]     bank_len,
  input  logic [TIME_W-1:0] bank_ref,
  input  logic              bank_found,
  output logic              rd_bank,
  output logic              rd_done,
  output logic [AW:0]       raddr,
  input  logic [CH_W-1:0]   r_chan,
  input  logic [TIME_W-1:0] r_time,
  input  logic              r_last,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [TIME_W:0]   out_time,
  output logic              out_last,
  output logic              out_noref
);
  localparam logic [CH_W-1:0] REF_ID = CH_W'(REF_CHAN);

  rd_state_t         state;
  logic [AW-1:0]     ptr;
  logic [LW-1:0]     len_q;
  logic [TIME_W-1:0] ref_q;
  logic              found_q;
  logic              rvalid;
  logic signed [TIME_W:0] hit_s, ref_s, diff_s;

  always_comb begin
    rd_done = (state == RD_RUN) && (LW'(ptr) == (len_q - 1'b1));
    raddr   = {rd_bank, ptr};
    hit_s   = $signed({1'b0, r_time});
    ref_s   = $signed({1'b0, ref_q});
    diff_s  = hit_s - ref_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RD_IDLE;
      rd_bank <= 1'b0;
      ptr     <= '0;
      len_q   <= '0;
      ref_q   <= '0;
      found_q <= 1'b0;
      rvalid  <= 1'b0;
    end else begin
      rvalid <= (state == RD_RUN);
      case (state)
        RD_IDLE: begin
          if (bank_ready) begin
            state   <= RD_RUN;
            ptr     <= '0;
            len_q   <= bank_len;
            ref_q   <= bank_ref;
            found_q <= bank_found;
          end
        end
        RD_RUN: begin
          if (rd_done) begin
            state   <= RD_IDLE;
            rd_bank <= ~rd_bank;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_time  <= '0;
      out_last  <= 1'b0;
      out_noref <= 1'b0;
    end else begin
      out_valid <= rvalid;
      out_chan  <= r_chan;
      out_last  <= r_last;
      out_noref <= !found_q;
      out_time  <= found_q ? diff_s : {1'b0, r_time};
    end
  end

  // R2: an event streams out without gaps until its final word
  assert_no_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  // R5: the earliest reference hit is zero, so reference words are never negative
  assert_ref_nonneg_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_noref && (out_chan == REF_ID)) |-> !out_time[TIME_W]);

  // R6: uncorrected times are raw unsigned values
  assert_raw_positive_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_noref) |-> !out_time[TIME_W]);
endmodule

// File: rtl/refsub_top.sv
module refsub_top #(
  parameter int CH_W     = 7,
  parameter int TIME_W   = 21,
  parameter int DEPTH    = 32,
  parameter int REF_CHAN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [TIME_W-1:0] in_time,
  input  logic              in_last,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [TIME_W:0]   out_time,
  output logic              out_last,
  output logic              out_noref
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int DW = 1 + CH_W + TIME_W;

  logic              wr_bank;
  logic [AW-1:0]     wr_cnt;
  logic              bank_full  [2];
  logic [LW-1:0]     bank_len   [2];
  logic [TIME_W-1:0] bank_ref   [2];
  logic              bank_found [2];

  logic [TIME_W-1:0] evt_ref;
  logic              evt_found;
  logic              rd_bank;
  logic              rd_done;
  logic [AW:0]       raddr;
  logic [DW-1:0]     rdata;

  refsub_ref_track #(.CH_W(CH_W), .TIME_W(TIME_W), .REF_CHAN(REF_CHAN)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_time(in_time), .in_last(in_last), .evt_ref(evt_ref), .evt_found(evt_found)
  );

  refsub_ram #(.AW(AW + 1), .DW(DW)) u_ram (
    .clk(clk), .we(in_valid), .waddr({wr_bank, wr_cnt}),
    .wdata({in_last, in_chan, in_time}), .raddr(raddr), .rdata(rdata)
  );

  refsub_reader #(.CH_W(CH_W), .TIME_W(TIME_W), .AW(AW), .LW(LW), .REF_CHAN(REF_CHAN)) u_reader (
    .clk(clk), .rst(rst),
    .bank_ready(bank_full[rd_bank]), .bank_len(bank_len[rd_bank]),
    .bank_ref(bank_ref[rd_bank]), .bank_found(bank_found[rd_bank]),
    .rd_bank(rd_bank), .rd_done(rd_done), .raddr(raddr),
    .r_chan(rdata[TIME_W +: CH_W]), .r_time(rdata[TIME_W-1:0]), .r_last(rdata[DW-1]),
    .out_valid(out_valid), .out_chan(out_chan), .out_time(out_time),
    .out_last(out_last), .out_noref(out_noref)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank <= 1'b0;
      wr_cnt  <= '0;
      for (int b = 0; b < 2; b++) begin
        bank_full[b]  <= 1'b0;
        bank_len[b]   <= '0;
        bank_ref[b]   <= '0;
        bank_found[b] <= 1'b0;
      end
    end else begin
      if (rd_done) bank_full[rd_bank] <= 1'b0;
      if (in_valid) begin
        if (in_last) begin
          wr_cnt              <= '0;
          wr_bank             <= ~wr_bank;
          bank_len[wr_bank]   <= LW'(wr_cnt) + 1'b1;
          bank_ref[wr_bank]   <= evt_ref;
          bank_found[wr_bank] <= evt_found;
          bank_full[wr_bank]  <= 1'b1;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
    end
  end

  // R8: a bank is never rewritten while its event still waits for playback
  assert_no_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !bank_full[wr_bank]);

  // R2: an event never exceeds DEPTH words
  assert_fits_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_last) |-> (LW'(wr_cnt) < LW'(DEPTH - 1)));

  // R1: nothing leaves the block before a full event was accepted
  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !bank_full[0] && !bank_full[1]) |-> !out_valid);
endmodule

// File: tb/tb_refsub_top.sv
module tb_refsub_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 7;
  localparam int TIME_W = 21;
  localparam int DEPTH = 32;
  localparam int REF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [CH_W-1:0] in_chan = '0;
  logic [TIME_W-1:0] in_time = '0;
  logic in_last = 1'b0;
  logic out_valid;
  logic [CH_W-1:0] out_chan;
  logic [TIME_W:0] out_time;
  logic out_last;
  logic out_noref;

  int tests = 0;
  int fails = 0;

  int ev_ch [64];
  int ev_t [64];
  int ev_n = 0;

  int e_ch[$], e_t[$], e_l[$], e_r[$];
  int o_ch[$], o_t[$], o_l[$], o_r[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  refsub_top #(.CH_W(CH_W), .TIME_W(TIME_W), .DEPTH(DEPTH), .REF_CHAN(REF)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_time(in_time), .in_last(in_last), .out_valid(out_valid),
    .out_chan(out_chan), .out_time(out_time), .out_last(out_last),
    .out_noref(out_noref)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      o_ch.push_back(int'(out_chan));
      o_t.push_back(int'($signed(out_time)));
      o_l.push_back(int'(out_last));
      o_r.push_back(int'(out_noref));
    end
  end

  task automatic put(input int i, input int ch, input int t);
    ev_ch[i] = ch;
    ev_t[i] = t;
    if (i + 1 > ev_n) ev_n = i + 1;
  endtask

  task automatic expect_event();
    int refv = 0;
    bit found = 0;
    for (int i = 0; i < ev_n; i++)
      if (ev_ch[i] == REF && (!found || ev_t[i] < refv)) begin
        refv = ev_t[i];
        found = 1;
      end
    for (int i = 0; i < ev_n; i++) begin
      e_ch.push_back(ev_ch[i]);
      e_t.push_back(found ? ev_t[i] - refv : ev_t[i]);
      e_l.push_back(i == ev_n - 1 ? 1 : 0);
      e_r.push_back(found ? 0 : 1);
    end
  endtask

  task automatic drive_event(input bit hold);
    expect_event();
    for (int i = 0; i < ev_n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_chan = CH_W'(ev_ch[i]);
      in_time = TIME_W'(ev_t[i]);
      in_last = (i == ev_n - 1);
    end
    ev_n = 0;
    if (!hold) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
    end
  endtask

  task automatic judge(input string tag);
    repeat (2 * DEPTH + 10) @(negedge clk);
    tests++;
    if (o_ch.size() != e_ch.size()) begin
      fails++;
      $display("FAIL %s word count: actual %0d expected %0d", tag, o_ch.size(), e_ch.size());
    end
    while (e_ch.size() > 0 && o_ch.size() > 0) begin
      int ach = o_ch.pop_front(), at = o_t.pop_front(), al = o_l.pop_front(), ar = o_r.pop_front();
      int xch = e_ch.pop_front(), xt = e_t.pop_front(), xl = e_l.pop_front(), xr = e_r.pop_front();
      tests++;
      if (ach != xch || at != xt || al != xl || ar != xr) begin
        fails++;
        $display("FAIL %s word: actual ch=%0d t=%0d last=%0d noref=%0d expected ch=%0d t=%0d last=%0d noref=%0d",
                 tag, ach, at, al, ar, xch, xt, xl, xr);
      end
    end
    e_ch.delete(); e_t.delete(); e_l.delete(); e_r.delete();
    o_ch.delete(); o_t.delete(); o_l.delete(); o_r.delete();
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    tests++;
    if (seen != 0) begin
      fails++;
      $display("FAIL R1 out_valid after reset: actual %0d cycles expected 0", seen);
    end
  endtask

  task automatic t_basic();
    put(0, REF, 5000); put(1, 1, 5400); put(2, 2, 7123); put(3, 9, 5001);
    drive_event(0);
    judge("R2 R3 ref first");
  endtask

  task automatic t_ref_last();
    put(0, 3, 100); put(1, 4, 9000); put(2, 6, 0); put(3, REF, 4000);
    drive_event(0);
    judge("R4 R3 ref last, negatives");
  endtask

  task automatic t_multi_ref();
    put(0, REF, 3000); put(1, 2, 2500); put(2, REF, 1200); put(3, REF, 2000); put(4, 8, 1199);
    drive_event(0);
    judge("R5 earliest ref");
  endtask

  task automatic t_noref();
    put(0, 1, 77); put(1, 2, 2097151); put(2, 4, 0);
    drive_event(0);
    judge("R6 no ref");
  endtask

  task automatic t_no_carry();
    put(0, REF, 10); put(1, 3, 50);
    drive_event(0);
    put(0, 3, 60); put(1, 6, 70);
    drive_event(0);
    judge("R7 no carry");
  endtask

  task automatic t_back_to_back();
    put(0, 1, 900); put(1, REF, 800); put(2, 2, 700); put(3, 3, 2000);
    drive_event(1);
    put(0, 4, 10); put(1, 5, 20); put(2, REF, 15); put(3, 6, 14);
    put(4, 7, 1000); put(5, REF, 30);
    drive_event(0);
    judge("R8 back to back");
  endtask

  task automatic t_single_and_full();
    put(0, REF, 123456);
    drive_event(0);
    put(0, 2, 4242);
    drive_event(0);
    judge("R2 R6 single word");
    for (int i = 0; i < DEPTH; i++) put(i, (i == 17) ? REF : (i % 4), 1000 + 37 * i);
    drive_event(0);
    judge("R2 R3 full depth");
    tests++;
    if (ev_n != 0) begin
      fails++;
      $display("FAIL R2 bench state: actual %0d expected 0", ev_n);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_ref_last();
    t_multi_ref();
    t_noref();
    t_no_carry();
    t_back_to_back();
    t_single_and_full();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule